// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers write data for a single page of a byte-wide storage array and then writes the whole page into the array in one timed write cycle. A controller first loads a start address. The upper address bits pick the page, and that page stays fixed until the next address load. The lower bits give the first in-page offset. Each byte strobe stores one byte at the current offset and marks that offset as valid. The offset then steps forward and wraps around inside the page, so it never carries into the next page.

A commit strobe copies every valid buffered byte into the array. The write takes a fixed number of clock cycles, set by a parameter, and `busy` is high for all of them. Offsets that were never loaded keep their old array contents. An abort, or a commit with nothing buffered, empties the buffer and starts no write cycle. The array comes out of reset erased to 0xFF. It is read through a registered read port that only ever shows committed data.

Top module: `pgc_top`

## Requirements
- R1: After reset `busy` is 0 and every array location reads 0xFF.
- R2: An address load takes the page from `addr_in[ADDR_W-1:OFF_W]` and the start offset from `addr_in[OFF_W-1:0]`, where OFF_W = log2(PAGE_BYTES). It also clears all valid flags. Committed bytes land only in that page.
- R3: Each accepted byte load advances the offset by one. From offset PAGE_BYTES-1 it wraps to offset 0 of the same page.
- R4: A byte loaded at an offset that already holds buffered data replaces the earlier value. Only the last value is committed.
- R5: A commit accepted while at least one offset is valid raises `busy` on the next clock. `busy` then stays high for exactly TWR_CYCLES cycles. The array takes the new data on the clock edge at which `busy` falls, and the valid flags clear on that same edge.
- R6: Offsets with no valid flag keep their previous array contents across a commit.
- R7: While `busy` is high, byte loads, address loads, commits and aborts are all ignored. The buffered data, page and offset stay unchanged.
- R8: An abort, or a commit with no valid offset, clears all valid flags and leaves `busy` low.
- R9: `rd_data` is the array content at `rd_addr`, registered with one cycle of latency. It never shows buffered data that has not been committed.
- R10: When several strobes are high in the same idle cycle, only one acts. The order of precedence is abort, then commit, then address load, then byte load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load start page and offset from `addr_in` |
| addr_in | input | ADDR_W | Start address |
| byte_load | input | 1 | Buffer `byte_in` at the current offset |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | Start the write cycle for the buffered bytes |
| abort | input | 1 | Discard the buffered bytes |
| busy | output | 1 | High while a write cycle is in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered array data |

## Verification
The bench builds the block with ADDR_W=7, PAGE_BYTES=32 and TWR_CYCLES=5. With these values the array has only four pages. Wrap-around, page confinement and untouched neighbour pages can therefore be checked with a few dozen byte loads. The short write cycle lets many commits run in one test, including strobes that arrive in the middle of a write cycle and strobes that arrive in the same cycle as each other.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ABORT,
        OP_COMMIT,
        OP_ADDR,
        OP_BYTE
    } op_t;

    function automatic op_t pick_op(input logic busy, input logic abort,
                                    input logic commit, input logic addr_load,
                                    input logic byte_load);
        if (busy)           return OP_NONE;
        else if (abort)     return OP_ABORT;
        else if (commit)    return OP_COMMIT;
        else if (addr_load) return OP_ADDR;
        else if (byte_load) return OP_BYTE;
        else                return OP_NONE;
    endfunction

endpackage

// File: rtl/pgc_buffer.sv
module pgc_buffer
    import pgc_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = 5,
    parameter int PG_W       = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_t                     op,
    input  logic [PG_W-1:0]         start_page,
    input  logic [OFF_W-1:0]        start_off,
    input  byte_t                   byte_in,
    input  logic                    drain,
    output logic [PG_W-1:0]         page,
    output logic [OFF_W-1:0]        off,
    output logic [PAGE_BYTES*8-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]   valid,
    output logic                    any_valid
);

    byte_t slot [PAGE_BYTES];

    assign any_valid = |valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            off   <= '0;
            valid <= '0;
        end else if (drain) begin
            valid <= '0;
        end else begin
            case (op)
                OP_ABORT:  valid <= '0;
                OP_COMMIT: if (!any_valid) valid <= '0;
                OP_ADDR: begin
                    page  <= start_page;
                    off   <= start_off;
                    valid <= '0;
                end
                OP_BYTE: begin
                    valid[off] <= 1'b1;
                    off        <= off + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !drain && op == OP_BYTE) slot[off] <= byte_in;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign data_flat[g*8 +: 8] = slot[g];
    end

endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
    parameter int TWR_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (TWR_CYCLES > 1) ? $clog2(TWR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TWR_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= LAST;
            end
        end else if (done) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pgc_array.sv
module pgc_array
    import pgc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = 5,
    parameter int PG_W       = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PG_W-1:0]         wr_page,
    input  logic [PAGE_BYTES*8-1:0] wr_data,
    input  logic [PAGE_BYTES-1:0]   wr_valid,
    input  logic [ADDR_W-1:0]       rd_addr,
    output byte_t                   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
        end else if (wr_en) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wr_valid[i]) mem[{wr_page, OFF_W'(i)}] <= wr_data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= 8'hFF;
        else     rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/pgc_top.sv
module pgc_top
    import pgc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int TWR_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_load,
    input  logic [7:0]        byte_in,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;

    op_t                     op;
    logic                    wr_done;
    logic                    start_wr;
    logic [PG_W-1:0]         buf_page;
    logic [OFF_W-1:0]        buf_off;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_valid;
    logic                    buf_any;

    assign op       = pick_op(busy, abort, commit, addr_load, byte_load);
    assign start_wr = (op == OP_COMMIT) && buf_any;

    pgc_buffer #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .start_page (addr_in[ADDR_W-1:OFF_W]),
        .start_off  (addr_in[OFF_W-1:0]),
        .byte_in    (byte_in),
        .drain      (wr_done),
        .page       (buf_page),
        .off        (buf_off),
        .data_flat  (buf_data),
        .valid      (buf_valid),
        .any_valid  (buf_any)
    );

    pgc_timer #(.TWR_CYCLES(TWR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start_wr),
        .busy  (busy),
        .done  (wr_done)
    );

    pgc_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W),
                .PG_W(PG_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_done),
        .wr_page  (buf_page),
        .wr_data  (buf_data),
        .wr_valid (buf_valid),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = 5,
    parameter int PG_W       = 5,
    parameter int TWR_CYCLES = 100
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  commit,
    input logic                  abort,
    input logic                  any_valid,
    input logic [PAGE_BYTES-1:0] valid,
    input logic [PG_W-1:0]       page,
    input logic [OFF_W-1:0]      off
);

    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst)       run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !busy); // R1

    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && commit && !abort && any_valid) |=> busy); // R5

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < TWR_CYCLES)); // R5

    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        (busy && run < TWR_CYCLES - 1) |=> busy); // R5

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(page) && $stable(off))); // R7

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!busy && abort) |=> (!busy && valid == '0)); // R8

    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!busy && commit && !any_valid) |=> !busy); // R8

endmodule

bind pgc_top pgc_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .OFF_W      (OFF_W),
    .PG_W       (PG_W),
    .TWR_CYCLES (TWR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .commit    (commit),
    .abort     (abort),
    .any_valid (buf_any),
    .valid     (buf_valid),
    .page      (buf_page),
    .off       (buf_off)
);

// File: tb/test_pgc_top.sv
module test_pgc_top;

    localparam int AW   = 7;
    localparam int PB   = 32;
    localparam int TWR  = 5;
    localparam int NMEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_load = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          busy;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    always #10 clk = ~clk;

    pgc_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .TWR_CYCLES(TWR)) i_pgc_top (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in), .commit(commit),
        .abort(abort), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R1";

    int mem [NMEM];
    int bd  [PB];
    bit bv  [PB];
    int pg, off, bcnt, rd_exp;

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic void clear_buf();
        for (int i = 0; i < PB; i++) bv[i] = 0;
    endfunction

    function automatic bit any_v();
        for (int i = 0; i < PB; i++) if (bv[i]) return 1;
        return 0;
    endfunction

    function automatic void model_edge();
        if (rst) begin
            for (int a = 0; a < NMEM; a++) mem[a] = 'hFF;
            clear_buf();
            pg = 0; off = 0; bcnt = 0; rd_exp = 'hFF;
        end else begin
            rd_exp = mem[rd_addr];
            if (bcnt > 0) begin
                if (bcnt == 1) begin
                    for (int i = 0; i < PB; i++) if (bv[i]) mem[pg*PB + i] = bd[i];
                    clear_buf();
                end
                bcnt--;
            end else if (abort) begin
                clear_buf();
            end else if (commit) begin
                if (any_v()) bcnt = TWR; else clear_buf();
            end else if (addr_load) begin
                pg = int'(addr_in) / PB; off = int'(addr_in) % PB; clear_buf();
            end else if (byte_load) begin
                bd[off] = byte_in; bv[off] = 1; off = (off + 1) % PB;
            end
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, busy, bcnt > 0, "busy");
        check(tag, rd_data, rd_exp, "rd_data");
        addr_load = 0; byte_load = 0; commit = 0; abort = 0;
    endtask

    task automatic set_addr(int a);
        addr_in = AW'(a); addr_load = 1; tick();
    endtask

    task automatic put(int d);
        byte_in = 8'(d); byte_load = 1; tick();
    endtask

    task automatic do_commit();
        commit = 1; tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic read_at(string req, int a, int exp);
        rd_addr = AW'(a); tick();
        check(req, rd_data, exp, "readback");
    endtask

    task automatic count_busy(string req);
        int n = 0;
        for (int i = 0; i < TWR + 3; i++) begin
            if (busy) n++;
            tick();
        end
        check(req, n, TWR, "busy length");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;
        tag = "R1";
        idle(1);
        check("R1", busy, 0, "busy after reset");
        read_at("R1", 0, 'hFF);
        read_at("R1", 127, 'hFF);

        tag = "R5";
        set_addr('h25);
        put('hA1);
        commit = 1; tick();
        count_busy("R5");
        read_at("R5", 'h25, 'hA1);

        tag = "R3";
        set_addr(2*PB + 30);
        put('h11); put('h22); put('h33); put('h44);
        do_commit(); idle(TWR + 1);
        read_at("R3", 2*PB + 30, 'h11);
        read_at("R3", 2*PB + 31, 'h22);
        read_at("R3", 2*PB + 0, 'h33);
        read_at("R2", 2*PB + 1, 'h44);
        read_at("R2", 3*PB + 0, 'hFF);

        tag = "R4";
        set_addr(0);
        for (int i = 0; i < PB + 2; i++) put(i + 'h40);
        do_commit(); idle(TWR + 1);
        read_at("R4", 0, 'h60);
        read_at("R4", 1, 'h61);
        read_at("R4", 2, 'h42);

        tag = "R6";
        set_addr(PB + 6);
        put('hB6); put('hB7);
        do_commit(); idle(TWR + 1);
        read_at("R6", PB + 5, 'hA1);
        read_at("R6", PB + 7, 'hB7);
        read_at("R6", PB + 8, 'hFF);

        tag = "R7";
        set_addr(3*PB);
        put('h77);
        do_commit();
        put('h99); set_addr(5); abort = 1; tick(); do_commit();
        idle(TWR);
        read_at("R7", 3*PB, 'h77);
        read_at("R7", 3*PB + 1, 'hFF);
        do_commit();
        check("R7", busy, 0, "load during busy was buffered");

        tag = "R9";
        set_addr(3*PB + 2);
        put('h5A);
        read_at("R9", 3*PB + 2, 'hFF);

        tag = "R8";
        abort = 1; tick();
        do_commit();
        check("R8", busy, 0, "abort then commit");
        read_at("R8", 3*PB + 2, 'hFF);
        do_commit();
        check("R8", busy, 0, "empty commit");

        tag = "R10";
        set_addr(3*PB + 10);
        put('hC1);
        byte_in = 'hEE; byte_load = 1; abort = 1; commit = 1; tick();
        do_commit();
        check("R10", busy, 0, "abort outranks commit");
        set_addr(3*PB + 12);
        put('hD1);
        addr_in = 'h0F; addr_load = 1; commit = 1; tick();
        check("R10", busy, 1, "commit outranks address load");
        idle(TWR + 1);
        read_at("R10", 3*PB + 12, 'hD1);
        addr_in = AW'(3*PB + 20); addr_load = 1; byte_in = 'h3C; byte_load = 1; tick();
        put('h3D);
        do_commit(); idle(TWR + 1);
        read_at("R10", 3*PB + 20, 'h3D);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule